// File: doc/BRIEF.md
# DMA Frame Address Generator

This block walks one DMA channel frame and produces, beat by beat, the source and destination addresses the bus master should use. A single start pulse captures a channel mode word, two base addresses, two stride values and a frame byte count. From then on every accepted beat moves each pointer according to its own address mode and reduces a remaining-byte counter. The counter always shows how much of the frame is still outstanding.

The two pointers are independent. Each can stay fixed, as for a peripheral data register. Each can step by the beat size, as for a linear buffer. Each can step by the beat size plus a programmable gap, as for a column of a 2-D buffer. Beats are either one byte or four bytes wide, and the last beat of a frame may carry fewer bytes than a full beat. One-cycle flags mark the point where half of the frame has been moved and the point where the whole frame has been moved. Data movement, bus protocol and descriptor fetching belong to the neighbouring blocks.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset `busy_o`, `beat_valid_o`, `half_o` and `done_o` are 0, and `remain_o`, `src_addr_o`, `dst_addr_o`, `src_type_o` and `dst_type_o` are all 0.
- R2: A `start_i` seen while idle loads the pointers with the two base addresses and `remain_o` with `frame_len_i`. The same pulse latches the peripheral/memory type fields, mode bits 9:8 for the source and 11:10 for the destination, onto `src_type_o`/`dst_type_o`. All of these are visible the cycle after the start, and `busy_o` is then 1 when the length is non-zero.
- R3: An address mode of 0 holds that pointer constant on every beat. The source mode is in mode bits 17:16 and the destination mode is in bits 19:18.
- R4: An address mode of 1 advances the pointer by the beat size on each accepted beat. The beat size is 4 bytes when mode bit 28 is 0 and 1 byte when it is 1.
- R5: An address mode of 2 advances the pointer by the beat size plus the side's 16-bit stride on each accepted beat. Addresses wrap modulo 2^32.
- R6: An address mode of 3 behaves exactly like mode 1.
- R7: Each accepted beat lowers `remain_o` by the beat size. When fewer bytes than a beat remain, `remain_o` goes to 0 and never wraps.
- R8: `half_o` is a one-cycle pulse, given once per frame. It appears in the cycle after the first beat that leaves the remaining count at or below half the frame length (2·remain ≤ length).
- R9: `done_o` pulses for one cycle in the cycle after the beat that empties the frame, and `busy_o` and `beat_valid_o` fall in that same cycle.
- R10: A `start_i` while busy is ignored, and so are changes on the configuration inputs during a frame.
- R11: A start with a frame length of 0 gives a `done_o` pulse in the next cycle, with `busy_o` staying 0 and no `half_o`.
- R12: While `beat_ready_i` is 0, or while the block is idle, neither pointer nor `remain_o` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures configuration when idle |
| mode_i | input | 32 | Channel mode word (types, address modes, beat width) |
| src_base_i | input | AW | Source start address |
| dst_base_i | input | AW | Destination start address |
| src_stride_i | input | SW | Extra source gap per beat in stride mode |
| dst_stride_i | input | SW | Extra destination gap per beat in stride mode |
| frame_len_i | input | FW | Frame length in bytes |
| beat_ready_i | input | 1 | Beat accepted by the master this cycle |
| beat_valid_o | output | 1 | A beat is offered at the current pointers |
| busy_o | output | 1 | Frame in progress |
| src_addr_o | output | AW | Current source pointer |
| dst_addr_o | output | AW | Current destination pointer |
| src_type_o | output | 2 | Latched source type field |
| dst_type_o | output | 2 | Latched destination type field |
| remain_o | output | FW | Bytes still to move in this frame |
| half_o | output | 1 | Half-frame pulse |
| done_o | output | 1 | End-of-frame pulse |

## Verification
Every result of this block sits one register away from its cause. Pointers, remaining count and latched types change one clock edge after the accepted start or beat. The half and done flags and the fall of busy appear in that same following cycle. The bench drives each stimulus on a falling edge and computes the model state that must hold after the next rising edge. It then compares all outputs at the following falling edge, so each comparison lands exactly one edge after the stimulus that caused it. Stalled and idle cycles are checked in the same way, against a model that does not move.

// File: rtl/dag_pkg.sv
package dag_pkg;

   typedef enum logic [1:0] {
      AM_HOLD   = 2'd0,
      AM_INC    = 2'd1,
      AM_STRIDE = 2'd2,
      AM_INC_X  = 2'd3
   } addr_mode_e;

   // positions inside the channel mode word
   localparam int SRC_TY_LSB = 8;
   localparam int DST_TY_LSB = 10;
   localparam int SRC_AM_LSB = 16;
   localparam int DST_AM_LSB = 18;
   localparam int NARROW_BIT = 28;

   typedef struct packed {
      addr_mode_e src_am;
      addr_mode_e dst_am;
      logic [1:0] src_ty;
      logic [1:0] dst_ty;
      logic       narrow;
   } chan_cfg_t;

   function automatic chan_cfg_t decode_mode(input logic [31:0] m);
      chan_cfg_t c;
      c.src_am = addr_mode_e'(m[SRC_AM_LSB +: 2]);
      c.dst_am = addr_mode_e'(m[DST_AM_LSB +: 2]);
      c.src_ty = m[SRC_TY_LSB +: 2];
      c.dst_ty = m[DST_TY_LSB +: 2];
      c.narrow = m[NARROW_BIT];
      return c;
   endfunction

   function automatic logic [2:0] beat_bytes(input logic narrow);
      return narrow ? 3'd1 : 3'd4;
   endfunction

endpackage

// File: rtl/dag_addr_unit.sv
module dag_addr_unit
   import dag_pkg::*;
#(
   parameter int AW = 32,
   parameter int SW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] base_i,
   input  logic          adv_i,
   input  addr_mode_e    mode_i,
   input  logic          narrow_i,
   input  logic [SW-1:0] stride_i,
   output logic [AW-1:0] addr_o
);

   logic [AW-1:0] size_w;
   logic [AW-1:0] step_w;
   logic [AW-1:0] addr_q;

   assign size_w = AW'(beat_bytes(narrow_i));

   always_comb begin
      unique case (mode_i)
         AM_HOLD:   step_w = '0;
         AM_STRIDE: step_w = size_w + AW'(stride_i);
         default:   step_w = size_w;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (load_i) addr_q <= base_i;
      else if (adv_i)  addr_q <= addr_q + step_w;
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/dag_frame_ctr.sv
module dag_frame_ctr
   import dag_pkg::*;
#(
   parameter int FW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [FW-1:0] len_i,
   input  logic          adv_i,
   input  logic          narrow_i,
   output logic [FW-1:0] remain_o,
   output logic          active_o,
   output logic          half_o,
   output logic          done_o
);

   localparam int CW = FW + 1;

   logic [FW-1:0] rem_q, len_q, take_w, nxt_w;
   logic          act_q, half_q, done_q, seen_q;
   logic          half_hit_w;

   assign take_w     = (rem_q < FW'(beat_bytes(narrow_i))) ? rem_q : FW'(beat_bytes(narrow_i));
   assign nxt_w      = rem_q - take_w;
   assign half_hit_w = ({nxt_w, 1'b0} <= CW'(len_q)) && !seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         len_q  <= '0;
         act_q  <= 1'b0;
         half_q <= 1'b0;
         done_q <= 1'b0;
         seen_q <= 1'b0;
      end else if (load_i) begin
         rem_q  <= len_i;
         len_q  <= len_i;
         act_q  <= (len_i != '0);
         half_q <= 1'b0;
         done_q <= (len_i == '0);
         seen_q <= 1'b0;
      end else if (adv_i && act_q) begin
         rem_q  <= nxt_w;
         act_q  <= (nxt_w != '0);
         half_q <= half_hit_w;
         done_q <= (nxt_w == '0);
         seen_q <= seen_q | half_hit_w;
      end else begin
         half_q <= 1'b0;
         done_q <= 1'b0;
      end
   end

   assign remain_o = rem_q;
   assign active_o = act_q;
   assign half_o   = half_q;
   assign done_o   = done_q;

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
   import dag_pkg::*;
#(
   parameter int AW = 32,
   parameter int SW = 16,
   parameter int FW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [31:0]   mode_i,
   input  logic [AW-1:0] src_base_i,
   input  logic [AW-1:0] dst_base_i,
   input  logic [SW-1:0] src_stride_i,
   input  logic [SW-1:0] dst_stride_i,
   input  logic [FW-1:0] frame_len_i,
   input  logic          beat_ready_i,
   output logic          beat_valid_o,
   output logic          busy_o,
   output logic [AW-1:0] src_addr_o,
   output logic [AW-1:0] dst_addr_o,
   output logic [1:0]    src_type_o,
   output logic [1:0]    dst_type_o,
   output logic [FW-1:0] remain_o,
   output logic          half_o,
   output logic          done_o
);

   localparam int NSIDE = 2;

   generate
      if (AW < 8)  begin : g_bad_aw $error("AW must be at least 8"); end
      if (SW > AW) begin : g_bad_sw $error("SW must not exceed AW"); end
      if (FW < 3)  begin : g_bad_fw $error("FW must be at least 3"); end
   endgenerate

   chan_cfg_t     cfg_q;
   logic          busy_w, accept_w, adv_w;
   addr_mode_e    am_src, am_dst;
   logic [AW-1:0] base_w   [NSIDE];
   logic [SW-1:0] stride_q [NSIDE];
   addr_mode_e    am_w     [NSIDE];
   logic [AW-1:0] addr_w   [NSIDE];

   assign accept_w = start_i && !busy_w;
   assign adv_w    = busy_w && beat_ready_i;
   assign am_src   = cfg_q.src_am;
   assign am_dst   = cfg_q.dst_am;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q       <= '0;
         stride_q[0] <= '0;
         stride_q[1] <= '0;
      end else if (accept_w) begin
         cfg_q       <= decode_mode(mode_i);
         stride_q[0] <= src_stride_i;
         stride_q[1] <= dst_stride_i;
      end
   end

   assign base_w[0] = src_base_i;
   assign base_w[1] = dst_base_i;
   assign am_w[0]   = am_src;
   assign am_w[1]   = am_dst;

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      dag_addr_unit #(.AW(AW), .SW(SW)) u_addr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_i   (accept_w),
         .base_i   (base_w[s]),
         .adv_i    (adv_w),
         .mode_i   (am_w[s]),
         .narrow_i (cfg_q.narrow),
         .stride_i (stride_q[s]),
         .addr_o   (addr_w[s])
      );
   end

   dag_frame_ctr #(.FW(FW)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept_w),
      .len_i    (frame_len_i),
      .adv_i    (adv_w),
      .narrow_i (cfg_q.narrow),
      .remain_o (remain_o),
      .active_o (busy_w),
      .half_o   (half_o),
      .done_o   (done_o)
   );

   assign busy_o       = busy_w;
   assign beat_valid_o = busy_w;
   assign src_addr_o   = addr_w[0];
   assign dst_addr_o   = addr_w[1];
   assign src_type_o   = cfg_q.src_ty;
   assign dst_type_o   = cfg_q.dst_ty;

endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
   parameter int AW = 32,
   parameter int FW = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          beat_ready_i,
   input logic          busy_o,
   input logic          half_o,
   input logic          done_o,
   input logic [FW-1:0] remain_o,
   input logic [AW-1:0] src_addr_o,
   input logic [AW-1:0] dst_addr_o,
   input logic [1:0]    src_am,
   input logic [1:0]    dst_am
);

   logic half_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  half_seen_q <= 1'b0;
      else if (start_i && !busy_o) half_seen_q <= 1'b0;
      else if (half_o)             half_seen_q <= 1'b1;
   end

   // R3
   const_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && beat_ready_i && src_am == 2'd0 |=> $stable(src_addr_o));

   // R3
   const_dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && beat_ready_i && dst_am == 2'd0 |=> $stable(dst_addr_o));

   // R7
   remain_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> remain_o <= $past(remain_o));

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && remain_o == '0);

   // R8
   half_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      half_o |-> !half_seen_q);

   // R12
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !beat_ready_i |=> $stable(src_addr_o) && $stable(dst_addr_o) && $stable(remain_o));

endmodule

bind dma_addr_gen dag_checker #(.AW(AW), .FW(FW)) u_dag_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .beat_ready_i (beat_ready_i),
   .busy_o       (busy_o),
   .half_o       (half_o),
   .done_o       (done_o),
   .remain_o     (remain_o),
   .src_addr_o   (src_addr_o),
   .dst_addr_o   (dst_addr_o),
   .src_am       (am_src),
   .dst_am       (am_dst)
);

// File: tb/dma_addr_gen_bench.sv
`timescale 1ns/1ps
module dma_addr_gen_bench;

   localparam int AW = 32;
   localparam int SW = 16;
   localparam int FW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [31:0]   mode_i = '0;
   logic [AW-1:0] src_base_i = '0, dst_base_i = '0;
   logic [SW-1:0] src_stride_i = '0, dst_stride_i = '0;
   logic [FW-1:0] frame_len_i = '0;
   logic          beat_ready_i = 1'b0;
   logic          beat_valid_o, busy_o, half_o, done_o;
   logic [AW-1:0] src_addr_o, dst_addr_o;
   logic [1:0]    src_type_o, dst_type_o;
   logic [FW-1:0] remain_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   dma_addr_gen #(.AW(AW), .SW(SW), .FW(FW)) u_dma_addr_gen (.*);

   // model state
   logic [AW-1:0] m_src, m_dst;
   logic [FW-1:0] m_rem, m_len;
   logic [1:0]    m_sam, m_dam, m_sty, m_dty;
   logic [SW-1:0] m_ss, m_ds;
   logic          m_narrow, m_busy, m_half, m_done, m_seen;
   string         t_src, t_dst, t_rem, t_done;

   function automatic logic [AW-1:0] step_of(input logic [1:0] am, input logic nar,
                                             input logic [SW-1:0] st);
      logic [AW-1:0] sz;
      sz = nar ? 1 : 4;
      if (am == 2'd0) return '0;
      if (am == 2'd2) return sz + AW'(st);
      return sz;
   endfunction

   function automatic string mode_tag(input logic [1:0] am);
      case (am)
         2'd0: return "R3";
         2'd1: return "R4";
         2'd2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp,
                      input string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      chk(t_src,  src_addr_o, m_src, "src_addr");
      chk(t_dst,  dst_addr_o, m_dst, "dst_addr");
      chk(t_rem,  AW'(remain_o), AW'(m_rem), "remain");
      chk("R9",   AW'({busy_o, beat_valid_o}), AW'({m_busy, m_busy}), "busy/valid");
      chk("R8",   AW'(half_o), AW'(m_half), "half");
      chk(t_done, AW'(done_o), AW'(m_done), "done");
      chk("R2",   AW'({src_type_o, dst_type_o}), AW'({m_sty, m_dty}), "types");
   endtask

   // drive at negedge, advance model, check at next negedge
   task automatic cycle(input logic st, input logic rdy, input logic [31:0] md,
                        input logic [AW-1:0] sb, input logic [AW-1:0] db,
                        input logic [SW-1:0] ss, input logic [SW-1:0] ds,
                        input logic [FW-1:0] len);
      logic [FW-1:0] sz, tk;
      start_i = st; beat_ready_i = rdy; mode_i = md;
      src_base_i = sb; dst_base_i = db; src_stride_i = ss; dst_stride_i = ds;
      frame_len_i = len;
      m_half = 1'b0; m_done = 1'b0;
      t_src = "R12"; t_dst = "R12"; t_rem = "R12"; t_done = "R9";
      if (st && !m_busy) begin
         m_src = sb; m_dst = db; m_rem = len; m_len = len;
         m_sam = md[17:16]; m_dam = md[19:18]; m_sty = md[9:8]; m_dty = md[11:10];
         m_narrow = md[28]; m_ss = ss; m_ds = ds; m_seen = 1'b0;
         m_busy = (len != 0); m_done = (len == 0);
         t_src = "R2"; t_dst = "R2"; t_rem = "R2";
         if (len == 0) t_done = "R11";
      end else if (m_busy && rdy) begin
         sz = m_narrow ? 1 : 4;
         tk = (m_rem < sz) ? m_rem : sz;
         m_rem = m_rem - tk;
         m_src = m_src + step_of(m_sam, m_narrow, m_ss);
         m_dst = m_dst + step_of(m_dam, m_narrow, m_ds);
         if (!m_seen && (2 * {1'b0, m_rem}) <= {1'b0, m_len}) begin
            m_half = 1'b1; m_seen = 1'b1;
         end
         m_done = (m_rem == 0);
         m_busy = (m_rem != 0);
         t_src = mode_tag(m_sam); t_dst = mode_tag(m_dam); t_rem = "R7";
      end else if (st) begin
         t_src = "R10"; t_dst = "R10"; t_rem = "R10";
      end
      @(negedge clk);
      check_all();
   endtask

   task automatic run_frame(input logic [31:0] md, input logic [AW-1:0] sb,
                            input logic [AW-1:0] db, input logic [SW-1:0] ss,
                            input logic [SW-1:0] ds, input logic [FW-1:0] len,
                            input int ready_pct);
      cycle(1'b1, $urandom_range(0, 1), md, sb, db, ss, ds, len);
      while (m_busy) begin
         cycle(($urandom_range(0, 9) == 0), ($urandom_range(1, 100) <= ready_pct),
               $urandom, $urandom, $urandom, SW'($urandom), SW'($urandom), FW'($urandom));
      end
      cycle(1'b0, 1'b1, $urandom, '0, '0, '0, '0, '0);
   endtask

   function automatic logic [31:0] mk_mode(input logic [1:0] sam, input logic [1:0] dam,
                                           input logic nar, input logic [1:0] sty,
                                           input logic [1:0] dty);
      logic [31:0] m;
      m = $urandom;
      m[17:16] = sam; m[19:18] = dam; m[28] = nar; m[9:8] = sty; m[11:10] = dty;
      return m;
   endfunction

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0A11));
      m_src = '0; m_dst = '0; m_rem = '0; m_len = '0; m_sam = '0; m_dam = '0;
      m_sty = '0; m_dty = '0; m_ss = '0; m_ds = '0;
      m_narrow = 1'b0; m_busy = 1'b0; m_half = 1'b0; m_done = 1'b0; m_seen = 1'b0;
      t_src = "R1"; t_dst = "R1"; t_rem = "R1"; t_done = "R1";
      repeat (3) @(negedge clk);
      check_all();   // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);
      // R12: idle ready pulses move nothing
      cycle(1'b0, 1'b1, '0, 32'h55, 32'h66, 16'h7, 16'h8, 20'h10);
      // directed corners
      run_frame(mk_mode(2'd1, 2'd0, 1'b0, 2'd2, 2'd0), 32'h1000, 32'h8000_0000, 0, 0, 20'd16, 100); // R4 R3
      run_frame(mk_mode(2'd2, 2'd2, 1'b1, 2'd3, 2'd2), 32'hFFFF_FFF0, 32'h200, 16'hFFFF, 16'h3, 20'd7, 60); // R5 wrap
      run_frame(mk_mode(2'd3, 2'd1, 1'b0, 2'd0, 2'd3), 32'h40, 32'h80, 0, 0, 20'd6, 80);   // R6 R7 partial
      run_frame(mk_mode(2'd1, 2'd1, 1'b0, 2'd2, 2'd2), 32'h0, 32'h0, 0, 0, 20'd1, 100);    // R8 R9 single short beat
      run_frame(mk_mode(2'd0, 2'd2, 1'b1, 2'd1, 2'd0), 32'h9, 32'hA, 0, 16'h10, 20'd0, 100); // R11 zero length
      run_frame(mk_mode(2'd1, 2'd3, 1'b1, 2'd2, 2'd3), 32'h0, 32'h0, 0, 0, 20'd3, 30);     // R8 odd length
      // random frames
      for (int i = 0; i < 60; i++) begin
         run_frame($urandom, $urandom, $urandom, SW'($urandom), SW'($urandom),
                   FW'($urandom_range(0, 80)), $urandom_range(20, 100));
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule